// File: doc/BRIEF.md
# Inverter leg gate-enable sequencer

This block turns per-leg pulse-width commands into gate-enable signals for the two switches of each half-bridge in an inverter. Each leg has one active-high command for the upper switch and one for the lower switch. The two commands first pass through a short synchroniser. A small decision table then settles which switch, if either, may conduct. Three conditions override every leg at once and drive all enables low:

- an active-low shutdown level;
- an already-digitised supply-healthy flag;
- a one-cycle fault-kill strobe.

A switch never turns on until the opposite switch of its own leg has been off for a programmable number of clock cycles. Turning off is never delayed. This keeps the two switches of one leg from conducting together, even when commands swap from one side to the other without a pause.

All outputs are registered. The fault strobe also clears the dead-time history. After a fault, every switch waits a full dead time before it may conduct again, whatever the commands are. The default dead time is 18 cycles, which is 180 ns at 100 MHz. That is short compared with one period of a 25 kHz switching pattern.

Top module: `inv_gate_ctrl`

## Requirements
- R1: While `rst` is high, and on the edge that ends it, all enables are low. Reset clears the dead-time history, so the first turn-on of any switch waits as if the opposite switch had just turned off.
- R2: A change on `hi_cmd` or `lo_cmd` reaches the enables on the (SYNC_STAGES+1)-th rising edge after it is applied, when nothing else holds the output back.
- R3: With leg commands {hi,lo} = 2'b10 only `hs_en` of that leg may be high. With 2'b01 only `ls_en` may be high. With 2'b00 both are low.
- R4: With leg commands {hi,lo} = 2'b11 both enables of that leg go low. The two enables of a leg are never high together.
- R5: When `shdn_n` is sampled low, every enable is low after that edge, whatever the commands are.
- R6: When `uv_ok` is sampled low, every enable is low after that edge, whatever the commands are.
- R7: When `fault_kill` is sampled high, every enable is low after that edge, and the dead-time history of every switch is cleared.
- R8: An enable may rise only at an edge where the opposite enable of the same leg has been sampled low at DEAD_CYC consecutive edges, counting that edge and counting from reset or the last fault strobe. It rises at the first such edge for which the synchronised command asks for it.
- R9: Turn-off takes effect on the same edge as the command that causes it. A switch that goes off and comes back on, while the opposite switch stays off, does so without any dead-time wait.
- R10: Each leg follows its own commands independently. The shutdown, supply-healthy and fault inputs act on all legs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | LEGS | Upper-switch command per leg, active high |
| lo_cmd | input | LEGS | Lower-switch command per leg, active high |
| shdn_n | input | 1 | Shutdown level, active low, synchronous to clk |
| uv_ok | input | 1 | Supply-healthy flag, high when the supply is above lockout |
| fault_kill | input | 1 | One-cycle fault strobe, synchronous to clk |
| hs_en | output | LEGS | Registered upper-switch gate enable per leg |
| ls_en | output | LEGS | Registered lower-switch gate enable per leg |

## Verification
The bench builds the block with three legs, a two-stage synchroniser and a dead time of five cycles. The short dead time lets direct side swaps, sub-dead-time gaps, fault recovery and long random switching runs all fit in a few thousand cycles. It also keeps the counter saturation edge easy to reach. With three legs, independent per-leg patterns and the shared overrides can be exercised against each other in the same cycles.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  // Leg command after synchronisation: bit 1 = upper, bit 0 = lower.
  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_LOW  = 2'b01,
    CMD_HIGH = 2'b10,
    CMD_BOTH = 2'b11
  } leg_cmd_t;

  // Bits needed to count 0..n inclusive (at least one).
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n + 1) : 1;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hb_turnon_gate.sv
module hb_turnon_gate #(
  parameter int DEAD_CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic opp_on,
  output logic ready
);

  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] SAT = CW'(DEAD_CYC - 1);

  logic [CW-1:0] gap_q;

  // Counts edges at which the opposite switch was seen off, saturating.
  always_ff @(posedge clk) begin
    if (rst || kill || opp_on) gap_q <= '0;
    else if (gap_q != SAT)     gap_q <= gap_q + 1'b1;
  end

  // This edge completes DEAD_CYC quiet edges when the count is saturated
  // and the opposite switch is still off.
  assign ready = !opp_on && (gap_q == SAT);

endmodule

// File: rtl/hb_leg_ctrl.sv
module hb_leg_ctrl
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_s,
  input  logic lo_s,
  input  logic allow,
  input  logic kill,
  output logic hs_en,
  output logic ls_en
);

  leg_cmd_t cmd;
  logic     want_h, want_l;
  logic     h_ready, l_ready;
  logic     hs_q, ls_q;

  hb_turnon_gate #(.DEAD_CYC(DEAD_CYC)) u_hgate (
    .clk(clk), .rst(rst), .kill(kill), .opp_on(ls_q), .ready(h_ready)
  );

  hb_turnon_gate #(.DEAD_CYC(DEAD_CYC)) u_lgate (
    .clk(clk), .rst(rst), .kill(kill), .opp_on(hs_q), .ready(l_ready)
  );

  always_comb begin
    cmd    = leg_cmd_t'({hi_s, lo_s});
    want_h = 1'b0;
    want_l = 1'b0;
    case (cmd)
      CMD_HIGH: want_h = allow;
      CMD_LOW:  want_l = allow;
      CMD_IDLE, CMD_BOTH: begin
        want_h = 1'b0;
        want_l = 1'b0;
      end
      default: begin
        want_h = 1'b0;
        want_l = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= want_h && h_ready;
      ls_q <= want_l && l_ready;
    end
  end

  assign hs_en = hs_q;
  assign ls_en = ls_q;

  // Independent run counters of edges each output was seen low.
  localparam int RW = cnt_width(DEAD_CYC);
  localparam logic [RW-1:0] RUN_MAX = RW'(DEAD_CYC);

  logic [RW-1:0] lo_run, hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      if (ls_q)                  lo_run <= '0;
      else if (lo_run != RUN_MAX) lo_run <= lo_run + 1'b1;
      if (hs_q)                  hi_run <= '0;
      else if (hi_run != RUN_MAX) hi_run <= hi_run + 1'b1;
    end
  end

  // R4: the two switches of a leg never conduct together
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));

  // R8: upper rises only after the lower side was quiet for the dead time
  p_dead_hs_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> (lo_run >= RUN_MAX));

  // R8: lower rises only after the upper side was quiet for the dead time
  p_dead_ls_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> (hi_run >= RUN_MAX));

  // R7: a fault strobe leaves the leg off on the following cycle
  p_kill_r7: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!hs_q && !ls_q));

endmodule

// File: rtl/inv_gate_ctrl.sv
module inv_gate_ctrl #(
  parameter int LEGS        = 3,
  parameter int DEAD_CYC    = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LEGS-1:0] hi_cmd,
  input  logic [LEGS-1:0] lo_cmd,
  input  logic            shdn_n,
  input  logic            uv_ok,
  input  logic            fault_kill,
  output logic [LEGS-1:0] hs_en,
  output logic [LEGS-1:0] ls_en
);

  localparam int SW = 2 * LEGS;

  logic [SW-1:0]   cmd_s;
  logic [LEGS-1:0] hi_s, lo_s;
  logic            allow;

  hb_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({hi_cmd, lo_cmd}), .q(cmd_s)
  );

  assign hi_s  = cmd_s[SW-1:LEGS];
  assign lo_s  = cmd_s[LEGS-1:0];
  assign allow = shdn_n && uv_ok && !fault_kill;

  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      hb_leg_ctrl #(.DEAD_CYC(DEAD_CYC)) u_leg (
        .clk   (clk),
        .rst   (rst),
        .hi_s  (hi_s[g]),
        .lo_s  (lo_s[g]),
        .allow (allow),
        .kill  (fault_kill),
        .hs_en (hs_en[g]),
        .ls_en (ls_en[g])
      );
    end
  endgenerate

  // R5: shutdown level forces every enable low on the next cycle
  p_shdn_r5: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (hs_en == '0 && ls_en == '0));

  // R6: supply lockout forces every enable low on the next cycle
  p_uv_r6: assert property (@(posedge clk) disable iff (rst)
    !uv_ok |=> (hs_en == '0 && ls_en == '0));

  // R7: fault strobe forces every enable low on the next cycle
  p_fault_r7: assert property (@(posedge clk) disable iff (rst)
    fault_kill |=> (hs_en == '0 && ls_en == '0));

endmodule

// File: tb/inv_gate_ctrl_tb_top.sv
module inv_gate_ctrl_tb_top;

  localparam int LEGS = 3;
  localparam int DEAD = 5;
  localparam int SYNC = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic [LEGS-1:0] hi_cmd, lo_cmd;
  logic            shdn_n, uv_ok, fault_kill;
  logic [LEGS-1:0] hs_en, ls_en;

  always #10 clk = ~clk;  // 50 MHz

  inv_gate_ctrl #(.LEGS(LEGS), .DEAD_CYC(DEAD), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .shdn_n(shdn_n), .uv_ok(uv_ok), .fault_kill(fault_kill),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // Behavioural reference: delayed command history and quiet-edge counts.
  int hist_h [LEGS][SYNC];
  int hist_l [LEGS][SYNC];
  int quiet_h [LEGS];  // edges the lower side was seen off
  int quiet_l [LEGS];  // edges the upper side was seen off
  bit exp_h [LEGS];
  bit exp_l [LEGS];

  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LEGS; l++) begin
        for (int s = 0; s < SYNC; s++) begin
          hist_h[l][s] = 0;
          hist_l[l][s] = 0;
        end
        quiet_h[l] = 0; quiet_l[l] = 0;
        exp_h[l] = 0;   exp_l[l] = 0;
      end
    end else begin
      for (int l = 0; l < LEGS; l++) begin
        bit h, lo, en, nh, nl;
        h  = hist_h[l][SYNC-1] != 0;
        lo = hist_l[l][SYNC-1] != 0;
        en = shdn_n && uv_ok && !fault_kill;
        nh = en && h && !lo && !exp_l[l] && (quiet_h[l] >= DEAD - 1);
        nl = en && lo && !h && !exp_h[l] && (quiet_l[l] >= DEAD - 1);
        quiet_h[l] = (fault_kill || exp_l[l]) ? 0 :
                     (quiet_h[l] < DEAD ? quiet_h[l] + 1 : quiet_h[l]);
        quiet_l[l] = (fault_kill || exp_h[l]) ? 0 :
                     (quiet_l[l] < DEAD ? quiet_l[l] + 1 : quiet_l[l]);
        exp_h[l] = nh;
        exp_l[l] = nl;
        for (int s = SYNC - 1; s > 0; s--) begin
          hist_h[l][s] = hist_h[l][s-1];
          hist_l[l][s] = hist_l[l][s-1];
        end
        hist_h[l][0] = int'(hi_cmd[l]);
        hist_l[l][0] = int'(lo_cmd[l]);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      for (int l = 0; l < LEGS; l++) begin
        if (hs_en[l] !== exp_h[l] || ls_en[l] !== exp_l[l]) begin
          fails++;
          $display("FAIL %s leg %0d cycle %0d: actual hs=%b ls=%b expected hs=%b ls=%b",
                   cur_req, l, vectors, hs_en[l], ls_en[l], exp_h[l], exp_l[l]);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1; hi_cmd = '0; lo_cmd = '0;
    shdn_n = 1; uv_ok = 1; fault_kill = 0;
    cur_req = "R1";
    step(5);
    // R1: first turn-on after reset waits the full dead time
    rst = 0; hi_cmd = 3'b001;
    step(12);
    // R2: latency through the synchroniser
    cur_req = "R2";
    hi_cmd = '0; step(6);
    hi_cmd = 3'b010; step(8);
    lo_cmd = 3'b000; hi_cmd = 3'b000; step(3);
    // R3: per-leg decision table
    cur_req = "R3";
    hi_cmd = 3'b100; lo_cmd = 3'b011; step(12);
    hi_cmd = 3'b000; lo_cmd = 3'b000; step(8);
    hi_cmd = 3'b011; lo_cmd = 3'b100; step(12);
    // R4: both commands high on a leg
    cur_req = "R4";
    hi_cmd = 3'b111; lo_cmd = 3'b111; step(10);
    hi_cmd = 3'b101; lo_cmd = 3'b111; step(10);
    // R8: direct side swaps
    cur_req = "R8";
    hi_cmd = 3'b111; lo_cmd = 3'b000; step(12);
    hi_cmd = 3'b000; lo_cmd = 3'b111; step(12);
    hi_cmd = 3'b111; lo_cmd = 3'b000; step(12);
    hi_cmd = 3'b000; lo_cmd = 3'b101; step(2);
    hi_cmd = 3'b101; lo_cmd = 3'b000; step(12);
    // R9: short off pulse on the same side returns without waiting
    cur_req = "R9";
    hi_cmd = 3'b111; step(8);
    hi_cmd = 3'b110; step(1);
    hi_cmd = 3'b111; step(10);
    // R5: shutdown level
    cur_req = "R5";
    shdn_n = 0; step(4);
    shdn_n = 1; step(10);
    // R6: supply lockout
    cur_req = "R6";
    uv_ok = 0; step(4);
    uv_ok = 1; step(10);
    // R7: fault strobe clears history
    cur_req = "R7";
    fault_kill = 1; step(1);
    fault_kill = 0; step(12);
    hi_cmd = 3'b000; lo_cmd = 3'b111; step(3);
    fault_kill = 1; step(1);
    fault_kill = 0; step(12);
    // R10: independent random switching with occasional overrides
    cur_req = "R10";
    for (int c = 0; c < 4000; c++) begin
      for (int l = 0; l < LEGS; l++) begin
        if (($urandom % 8) == 0) begin
          int v;
          v = int'($urandom % 4);
          hi_cmd[l] = v[1];
          lo_cmd[l] = v[0];
        end
      end
      shdn_n     = ($urandom % 300) != 0;
      uv_ok      = ($urandom % 400) != 0;
      fault_kill = ($urandom % 250) == 0;
      step(1);
    end
    shdn_n = 1; uv_ok = 1; fault_kill = 0; step(12);
    done = 1;
    summary();
    $finish;
  end

endmodule